// File: doc/BRIEF.md
# Keyboard Character Receiver Port

This block sits on a processor's memory-mapped I/O bus and accepts characters from a byte-wide key source, one at a time. Each key event stores its byte in a one-character holding register and raises a ready flag. Software either polls the ready flag in the status/control word or enables an interrupt request. The request drives one pending line of the processor's cause register, the keyboard line at bit 8.

The bus port is single-cycle. Read data is valid combinationally in the cycle the access is presented. Writes and read side effects take effect at the next clock edge. Two word addresses are decoded: a status/control word at the base address `0xFFFF0000` and a character word at `0xFFFF0004`. All other addresses read as zero and ignore writes.

Top module: `kbd_rx_port`

## Requirements
- R1: After reset, the status/control word reads 0, the character word reads 0, and `irq` is low.
- R2: A cycle with `key_valid` high stores `key_byte`. From the next cycle, the character word reads that byte zero-extended to 32 bits, and status bit 0 (ready) reads 1.
- R3: A read of the character word in a cycle without `key_valid` clears ready from the next cycle.
- R4: A write to the status/control word loads bit 1 (interrupt enable) from write-data bit 1, which then reads back in status bit 1. Bit 0 cannot be written, and all other status bits read 0.
- R5: `irq` is high exactly when ready and interrupt enable are both 1. It stays high across status reads until the character word is read.
- R6: With interrupt enable at 0, key events set ready but leave `irq` low.
- R7: A key event while ready is already 1 replaces the held byte, and ready stays 1.
- R8: Writes to the character word do not change the held byte or ready.
- R9: When a key event and a character-word read fall in the same cycle, the read returns the previously held byte. The new byte is stored, and ready is 1 afterwards.
- R10: Accesses to any address other than the two decoded words read 0 and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| key_valid | input | 1 | One-cycle strobe marking a new character |
| key_byte | input | 8 | Character code accompanying `key_valid` |
| irq | output | 1 | Level interrupt request to the cause pending line |

## Verification
Key arrival and the consuming read of the character word can land in the same clock cycle. In that case the ready flag gets a set and a clear at the same edge, and the held byte is both being returned and replaced. The bench first stores one character. It then presents the next `key_valid` strobe together with a character-word read in the same cycle. It checks that the read returns the older byte, and that afterwards ready is 1 and the character word holds the newer byte. The overwrite case, a key arriving while ready is already set, is judged the same way through the status word and the character word.

// File: rtl/kbd_rx_port.sv
module kbd_rx_port #(
  parameter logic [31:0] BASE_ADDR = 32'hFFFF_0000,
  parameter int          DATA_W    = 32,
  parameter int          CHAR_W    = 8,
  parameter int          RDY_BIT   = 0,
  parameter int          IE_BIT    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [31:0]       bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              key_valid,
  input  logic [CHAR_W-1:0] key_byte,
  output logic              irq
);
  localparam logic [31:0] CTRL_ADDR = BASE_ADDR;
  localparam logic [31:0] DATA_ADDR = BASE_ADDR + 32'd4;
  localparam int          PAD_W     = DATA_W - CHAR_W;

  logic              ready_q, ie_q;
  logic [CHAR_W-1:0] held_q;

  wire hit_ctrl = bus_sel && (bus_addr == CTRL_ADDR);
  wire hit_data = bus_sel && (bus_addr == DATA_ADDR);
  wire ctrl_wr  = hit_ctrl && bus_we;
  wire data_rd  = hit_data && !bus_we;

  logic unused_wbits;
  assign unused_wbits = ^bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      ie_q    <= 1'b0;
      held_q  <= '0;
    end else begin
      if (ctrl_wr) ie_q <= bus_wdata[IE_BIT];
      if (key_valid) begin
        held_q  <= key_byte;
        ready_q <= 1'b1;
      end else if (data_rd) begin
        ready_q <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we) begin
      if (hit_ctrl) begin
        bus_rdata[RDY_BIT] = ready_q;
        bus_rdata[IE_BIT]  = ie_q;
      end else if (hit_data) begin
        bus_rdata = {{PAD_W{1'b0}}, held_q};
      end
    end
  end

  assign irq = ready_q & ie_q;

  // R2
  key_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |=> (ready_q && held_q == $past(key_byte)));

  // R3
  read_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !key_valid) |=> !ready_q);

  // R4
  ie_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (ie_q == $past(bus_wdata[IE_BIT])));

  // R8
  data_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_data && bus_we && !key_valid) |=> ($stable(held_q) && $stable(ready_q)));

  // R5
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !data_rd && !ctrl_wr) |=> irq);

  // R10
  stray_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !hit_ctrl && !hit_data && !key_valid) |=>
      ($stable(held_q) && $stable(ready_q) && $stable(ie_q)));
endmodule

// File: tb/kbd_rx_port_tb_top.sv
module kbd_rx_port_tb_top;
  localparam logic [31:0] CTRL = 32'hFFFF_0000;
  localparam logic [31:0] DATA = 32'hFFFF_0004;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 0, bus_we = 0, key_valid = 0;
  logic [31:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic [7:0] key_byte = '0;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  kbd_rx_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .key_valid(key_valid), .key_byte(key_byte), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic press(input logic [7:0] b);
    @(negedge clk);
    key_valid = 1; key_byte = b;
    @(negedge clk);
    key_valid = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq", {31'b0, irq}, 0);
    rd(CTRL, d); chk("R1 ctrl", d, 0);
    rd(DATA, d); chk("R1 data", d, 0);
  endtask

  task automatic t_key();
    logic [31:0] d;
    press(8'hC3);
    rd(CTRL, d); chk("R2 ready", d, 32'h1);
    rd(DATA, d); chk("R2 zero-extended byte", d, 32'h0000_00C3);
    rd(CTRL, d); chk("R3 ready cleared", d, 32'h0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(CTRL, 32'hFFFF_FFFE);
    rd(CTRL, d); chk("R4 ie set, other bits 0", d, 32'h2);
    wr(CTRL, 32'h1);
    rd(CTRL, d); chk("R4 bit0 read-only, ie cleared", d, 32'h0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(CTRL, 32'h2);
    chk("R5 irq idle", {31'b0, irq}, 0);
    press(8'h5A);
    chk("R5 irq raised", {31'b0, irq}, 1);
    rd(CTRL, d); chk("R5 ctrl", d, 32'h3);
    chk("R5 irq held after status read", {31'b0, irq}, 1);
    rd(DATA, d); chk("R5 data", d, 32'h5A);
    chk("R5 irq dropped", {31'b0, irq}, 0);
  endtask

  task automatic t_no_irq();
    logic [31:0] d;
    wr(CTRL, 32'h0);
    press(8'h33);
    chk("R6 no irq", {31'b0, irq}, 0);
    rd(CTRL, d); chk("R6 ready only", d, 32'h1);
    rd(DATA, d);
  endtask

  task automatic t_overwrite();
    logic [31:0] d;
    press(8'h10);
    press(8'h20);
    rd(CTRL, d); chk("R7 ready kept", d, 32'h1);
    rd(DATA, d); chk("R7 newer byte", d, 32'h20);
  endtask

  task automatic t_data_write();
    logic [31:0] d;
    press(8'h77);
    wr(DATA, 32'hFF);
    rd(CTRL, d); chk("R8 ready unchanged", d, 32'h1);
    rd(DATA, d); chk("R8 byte unchanged", d, 32'h77);
  endtask

  task automatic t_collision();
    logic [31:0] d;
    press(8'h61);
    @(negedge clk);
    key_valid = 1; key_byte = 8'h62;
    bus_sel = 1; bus_we = 0; bus_addr = DATA;
    #1 d = bus_rdata;
    @(negedge clk);
    key_valid = 0; bus_sel = 0;
    chk("R9 read returns old byte", d, 32'h61);
    rd(CTRL, d); chk("R9 ready set", d, 32'h1);
    rd(DATA, d); chk("R9 new byte held", d, 32'h62);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(32'hFFFF_0008, 32'h2);
    wr(32'h0000_0000, 32'h2);
    rd(CTRL, d); chk("R10 ie untouched", d, 32'h0);
    press(8'h44);
    rd(32'hFFFF_0008, d); chk("R10 stray read zero", d, 32'h0);
    rd(32'h0000_0004, d); chk("R10 stray read zero low", d, 32'h0);
    rd(CTRL, d); chk("R10 ready untouched", d, 32'h1);
    rd(DATA, d); chk("R10 byte", d, 32'h44);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_key();
    t_enable();
    t_irq();
    t_no_irq();
    t_overwrite();
    t_data_write();
    t_collision();
    t_unmapped();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule